// File: doc/BRIEF.md
# Dual Wiper Position Register with Tap Decode

This block holds the wiper position of each of two digitally set potentiometers. Every pot owns a 6-bit position register. The register's value is decoded into a one-hot select over the 64 tap switches of that pot's resistor string. Position 0 sits on the low terminal. Position 63 sits on the high terminal.

A position can change in four ways. The host can write a value directly. The register can copy one of its pot's four stored data registers. It can move one tap up or down at a time. It copies its own data register 0 while reset is held and whenever the recall strobe fires. The command decoder upstream drives all of these as single-cycle strobes, with a pot select and a data-register index alongside. The stored data register contents arrive as a flat input bus.

Every strobe is accepted in the cycle it is high, and the result is visible after the next rising clock edge. There is no back-pressure, so the interface has no valid/ready pair. When several strobes arrive in the same cycle, the one with the highest priority wins.

Top module: `wpr_bank`

## Requirements
- R1: Each pot i presents its 6-bit position on `pos[i*6 +: 6]`. Its tap select on `tap_sel[i*64 +: 64]` has bit j set exactly when the position equals j, so position 0 selects the low-terminal tap and position 63 selects the high-terminal tap.
- R2: Each pot's 64-bit tap select has exactly one bit set in every cycle, including the cycle right after a load.
- R3: A `step_stb` with `step_up`=1 adds one to the position of the pot named by `pot_sel`. With `step_up`=0 it subtracts one.
- R4: While `rst_n` is low, and in the cycle after `recall_stb`, every pot's position becomes its own data register 0. Data register k of pot i is `dr_bus[(i*4+k)*6 +: 6]`.
- R5: A `par_ld` with `par_all`=0 copies data register `reg_sel` of the pot named by `pot_sel` into that pot's position.
- R6: A step up at 63 leaves the position at 63. A step down at 0 leaves it at 0.
- R7: A `par_ld` with `par_all`=1 copies data register `reg_sel` of each pot into that pot's position, for both pots in the same cycle. `pot_sel` is ignored.
- R8: A `wr_ld` writes `wr_data` into the position of the pot named by `pot_sel`.
- R9: When strobes coincide, the winner is chosen in this order: recall (reset or `recall_stb`) first, then parallel load, then direct write, then step.
- R10: A pot's position is unchanged in any cycle where no strobe applies to it. This includes single-pot strobes that name the other pot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; recalls data register 0 while low |
| recall_stb | input | 1 | Recall data register 0 into both pots |
| par_ld | input | 1 | Parallel load from a data register |
| par_all | input | 1 | Parallel load applies to both pots |
| wr_ld | input | 1 | Direct write of `wr_data` |
| wr_data | input | 6 | Value for direct write |
| step_stb | input | 1 | One-tap step |
| step_up | input | 1 | Step direction, 1 = toward the high terminal |
| pot_sel | input | 1 | Pot addressed by single-pot strobes |
| reg_sel | input | 2 | Data register index for parallel loads |
| dr_bus | input | 48 | Data register contents, 4 per pot |
| pos | output | 12 | Current positions for readback |
| tap_sel | output | 128 | One-hot tap selects, 64 per pot |

## Verification
The collisions that matter are a parallel load, a direct write and a step that all land on one pot in one cycle, and a recall that arrives together with loads. The bench raises these strobes in the same cycle. It then checks that the position equals the value from the highest-priority source, and that the tap select still has a single bit at that index. Saturation at both ends is driven by stepping against a boundary reached through a load. The result must hold the boundary value.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam int POS_W = 6;
  localparam int N_POT = 2;
  localparam int N_DR  = 4;

  typedef enum logic [1:0] {
    SRC_HOLD,
    SRC_STEP,
    SRC_WRITE,
    SRC_LOAD
  } wpr_src_e;

  typedef struct packed {
    logic recall;
    logic par_en;
    logic wr_en;
    logic step_en;
    logic step_up;
  } wpr_ctl_t;
endpackage

// File: rtl/wpr_cell.sv
module wpr_cell
  import wpr_pkg::*;
#(
  parameter int W   = 6,
  parameter int NDR = 4,
  localparam int IW = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic             clk,
  input  wpr_ctl_t         ctl,
  input  logic [IW-1:0]    dr_idx,
  input  logic [NDR*W-1:0] dr_vec,
  input  logic [W-1:0]     wr_val,
  output logic [W-1:0]     pos
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = '0;

  logic [W-1:0] pick;
  logic [W-1:0] stepped;
  logic [W-1:0] nxt;

  // selected data register
  always_comb begin
    pick = dr_vec[W-1:0];
    for (int k = 0; k < NDR; k++) begin
      if (dr_idx == IW'(k)) pick = dr_vec[k*W +: W];
    end
  end

  // saturating step
  always_comb begin
    stepped = pos;
    if (ctl.step_up) begin
      if (pos != TOP) stepped = pos + 1'b1;
    end else begin
      if (pos != BOT) stepped = pos - 1'b1;
    end
  end

  // fixed priority: recall, parallel, write, step
  always_comb begin
    if (ctl.recall)       nxt = dr_vec[W-1:0];
    else if (ctl.par_en)  nxt = pick;
    else if (ctl.wr_en)   nxt = wr_val;
    else if (ctl.step_en) nxt = stepped;
    else                  nxt = pos;
  end

  always_ff @(posedge clk) begin
    pos <= nxt;
  end
endmodule

// File: rtl/wpr_tap_dec.sv
module wpr_tap_dec #(
  parameter int W = 6,
  localparam int NT = 1 << W
) (
  input  logic [W-1:0]  pos,
  output logic [NT-1:0] tap
);
  for (genvar j = 0; j < NT; j++) begin : g_tap
    assign tap[j] = (pos == W'(j));
  end
endmodule

// File: rtl/wpr_bank.sv
module wpr_bank
  import wpr_pkg::*;
#(
  parameter int W    = POS_W,
  parameter int NP   = N_POT,
  parameter int NDR  = N_DR,
  localparam int PSW = (NP > 1) ? $clog2(NP) : 1,
  localparam int RSW = (NDR > 1) ? $clog2(NDR) : 1,
  localparam int NT  = 1 << W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                recall_stb,
  input  logic                par_ld,
  input  logic                par_all,
  input  logic                wr_ld,
  input  logic [W-1:0]        wr_data,
  input  logic                step_stb,
  input  logic                step_up,
  input  logic [PSW-1:0]      pot_sel,
  input  logic [RSW-1:0]      reg_sel,
  input  logic [NP*NDR*W-1:0] dr_bus,
  output logic [NP*W-1:0]     pos,
  output logic [NP*NT-1:0]    tap_sel
);
  logic recall_any;
  assign recall_any = !rst_n || recall_stb;

  for (genvar i = 0; i < NP; i++) begin : g_pot
    logic     me;
    wpr_ctl_t ctl;

    assign me          = (pot_sel == PSW'(i));
    assign ctl.recall  = recall_any;
    assign ctl.par_en  = par_ld && (par_all || me);
    assign ctl.wr_en   = wr_ld && me;
    assign ctl.step_en = step_stb && me;
    assign ctl.step_up = step_up;

    wpr_cell #(.W(W), .NDR(NDR)) u_cell (
      .clk    (clk),
      .ctl    (ctl),
      .dr_idx (reg_sel),
      .dr_vec (dr_bus[i*NDR*W +: NDR*W]),
      .wr_val (wr_data),
      .pos    (pos[i*W +: W])
    );

    wpr_tap_dec #(.W(W)) u_dec (
      .pos (pos[i*W +: W]),
      .tap (tap_sel[i*NT +: NT])
    );
  end
endmodule

// File: rtl/wpr_chk.sv
module wpr_chk #(
  parameter int W   = 6,
  parameter int NP  = 2,
  parameter int NDR = 4,
  localparam int PSW = (NP > 1) ? $clog2(NP) : 1,
  localparam int NT  = 1 << W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                recall_stb,
  input logic                par_ld,
  input logic                wr_ld,
  input logic                step_stb,
  input logic                step_up,
  input logic [PSW-1:0]      pot_sel,
  input logic [NP*NDR*W-1:0] dr_bus,
  input logic [NP*W-1:0]     pos,
  input logic [NP*NT-1:0]    tap_sel
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  for (genvar i = 0; i < NP; i++) begin : g_c
    logic only_step;
    assign only_step = step_stb && (pot_sel == PSW'(i)) && !recall_stb && !par_ld && !wr_ld;

    p_one_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel[i*NT +: NT]) == 1);

    p_tap_at_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tap_sel[i*NT + int'(pos[i*W +: W])]);

    p_recall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      recall_stb |=> pos[i*W +: W] == $past(dr_bus[i*NDR*W +: W]));

    p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (only_step && step_up && pos[i*W +: W] != TOP) |=> pos[i*W +: W] == $past(pos[i*W +: W]) + 1'b1);

    p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (only_step && step_up && pos[i*W +: W] == TOP) |=> pos[i*W +: W] == TOP);

    p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (only_step && !step_up && pos[i*W +: W] == '0) |=> pos[i*W +: W] == '0);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall_stb && !par_ld && !wr_ld && !step_stb) |=> $stable(pos[i*W +: W]));
  end
endmodule

bind wpr_bank wpr_chk #(.W(W), .NP(NP), .NDR(NDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .recall_stb (recall_stb),
  .par_ld     (par_ld),
  .wr_ld      (wr_ld),
  .step_stb   (step_stb),
  .step_up    (step_up),
  .pot_sel    (pot_sel),
  .dr_bus     (dr_bus),
  .pos        (pos),
  .tap_sel    (tap_sel)
);

// File: tb/sim_wpr_bank.sv
module sim_wpr_bank;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, recall_stb, par_ld, par_all, wr_ld, step_stb, step_up, pot_sel;
  logic [1:0]   reg_sel;
  logic [5:0]   wr_data;
  logic [47:0]  dr_bus;
  logic [11:0]  pos;
  logic [127:0] tap_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wpr_bank u0 (
    .clk(clk), .rst_n(rst_n), .recall_stb(recall_stb), .par_ld(par_ld),
    .par_all(par_all), .wr_ld(wr_ld), .wr_data(wr_data), .step_stb(step_stb),
    .step_up(step_up), .pot_sel(pot_sel), .reg_sel(reg_sel), .dr_bus(dr_bus),
    .pos(pos), .tap_sel(tap_sel)
  );

  // {recall, par, all, wr, step, up, psel, rsel[2], wdata[6], exp0[6], exp1[6]}
  localparam int NV = 13;
  localparam logic [26:0] VEC [NV] = '{
    {7'b0001000, 2'd0, 6'd42, 6'd42, 6'd9 },  // R8 write pot0
    {7'b0000111, 2'd0, 6'd0,  6'd42, 6'd10},  // R3 up pot1
    {7'b0000100, 2'd0, 6'd0,  6'd41, 6'd10},  // R3 down pot0
    {7'b0100001, 2'd3, 6'd0,  6'd41, 6'd62},  // R5 load pot1 reg3
    {7'b0000111, 2'd0, 6'd0,  6'd41, 6'd63},  // R3 up to top
    {7'b0000111, 2'd0, 6'd0,  6'd41, 6'd63},  // R6 saturate top
    {7'b0110001, 2'd1, 6'd0,  6'd20, 6'd33},  // R7 global reg1
    {7'b0001001, 2'd0, 6'd0,  6'd20, 6'd0 },  // R8 write pot1
    {7'b0000101, 2'd0, 6'd0,  6'd20, 6'd0 },  // R6 saturate bottom
    {7'b0101110, 2'd2, 6'd7,  6'd40, 6'd0 },  // R9 par beats wr and step
    {7'b0001110, 2'd0, 6'd3,  6'd3,  6'd0 },  // R9 wr beats step
    {7'b1101001, 2'd0, 6'd11, 6'd5,  6'd9 },  // R9 recall beats all
    {7'b0000000, 2'd0, 6'd0,  6'd5,  6'd9 }   // R10 idle
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_pots(input string req, input logic [5:0] e0, input logic [5:0] e1);
    chk(req, 128'(pos[5:0]), 128'(e0));
    chk(req, 128'(pos[11:6]), 128'(e1));
    chk({req, " R1 R2 tap"}, tap_sel, {(64'd1 << e1), (64'd1 << e0)});
  endtask

  task automatic idle_in();
    recall_stb = 0; par_ld = 0; par_all = 0; wr_ld = 0; step_stb = 0;
    step_up = 0; pot_sel = 0; reg_sel = 0; wr_data = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // pot0 regs 5,20,40,63 ; pot1 regs 9,33,1,62
    dr_bus = {6'd62, 6'd1, 6'd33, 6'd9, 6'd63, 6'd40, 6'd20, 6'd5};
    idle_in();
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk_pots("R4 reset recall", 6'd5, 6'd9);
    rst_n = 1;
    @(negedge clk);
    chk_pots("R10 after reset", 6'd5, 6'd9);

    for (int v = 0; v < NV; v++) begin
      {recall_stb, par_ld, par_all, wr_ld, step_stb, step_up, pot_sel} = VEC[v][26:20];
      reg_sel = VEC[v][19:18];
      wr_data = VEC[v][17:12];
      @(negedge clk);
      idle_in();
      chk_pots($sformatf("vec%0d", v), VEC[v][11:6], VEC[v][5:0]);
    end

    // R4: recall picks up changed data register 0
    dr_bus[5:0] = 6'd0;
    dr_bus[29:24] = 6'd63;
    recall_stb = 1;
    @(negedge clk);
    idle_in();
    chk_pots("R4 recall new values", 6'd0, 6'd63);

    // R6 at bottom for pot0, R10 pot1 untouched
    step_stb = 1; step_up = 0; pot_sel = 0;
    @(negedge clk);
    idle_in();
    chk_pots("R6 R10 bottom pot0", 6'd0, 6'd63);

    // R5 single-pot load leaves other pot
    par_ld = 1; pot_sel = 0; reg_sel = 2'd3;
    @(negedge clk);
    idle_in();
    chk_pots("R5 R10 load pot0", 6'd63, 6'd63);

    // R3 down on pot1 while pot0 sits at top
    step_stb = 1; step_up = 0; pot_sel = 1;
    @(negedge clk);
    idle_in();
    chk_pots("R3 down pot1", 6'd63, 6'd62);

    // R4 reset holds recall while asserted with other strobes
    rst_n = 0; wr_ld = 1; wr_data = 6'd17; pot_sel = 0;
    @(negedge clk);
    idle_in();
    rst_n = 1;
    chk_pots("R4 R9 reset over write", 6'd0, 6'd63);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule